// File: doc/BRIEF.md
# Packet Receive DMA Engine

This block is the receive-side DMA channel of a serial communications controller. It takes bytes from the head of a receive FIFO and writes them, one byte per bus transfer, to consecutive addresses in system memory. Software sets a 24-bit buffer start address and a maximum buffer length through a small byte-wide register window. It then arms the channel by setting an enable bit. While armed, the engine raises a memory write request whenever the FIFO holds data, and it moves one byte for every cycle in which the bus grants that request.

A run ends in one of two ways. If the number of bytes written reaches the programmed length, the engine halts, even in the middle of a frame, and pulses a buffer-full interrupt. If a byte marked as the last of its frame is written first, the engine halts, keeps the number of bytes written readable, and pulses a frame-end interrupt. In both cases the enable bit clears itself and the FIFO stops being drained, so the serial side feels back-pressure. To restart, software loads a fresh start address and writes the length-high register with the enable bit set. That same write can also change the upper part of the length.

Top module: `rx_dma_engine`

## Requirements
- R1: After reset, every register reads 0, and `mem_req`, `fifo_pop`, `irq_full` and `irq_end` are low.
- R2: Register offsets: 0, 1 and 2 hold the start address bytes from least to most significant; 3 holds length bits 7:0; 4 holds length bits 14:8 in bits 6:0 and the enable bit in bit 7; 5 and 6 read the byte count (bits 7:0, then bits 14:8 in bits 6:0). Every writable register reads back its value.
- R3: A write to offset 4 with bit 7 set, while the engine is stopped and the resulting length is non-zero, arms the engine. Arming sets the enable bit, clears the byte count and starts the write pointer at the start address.
- R4: The arming write also loads length bits 14:8 from its bits 6:0. The new length governs the run that the write starts.
- R5: While armed with the FIFO not empty, `mem_req` is high, `mem_addr` is the write pointer and `mem_data` is the FIFO head. Each cycle with `mem_req` and `mem_gnt` both high writes one byte, pops the FIFO in the same cycle, and advances the pointer by 1, wrapping from FFFFFF to 000000.
- R6: A request that is not granted stays asserted with `mem_addr` and `mem_data` unchanged.
- R7: When a written byte makes the count equal to the length, the engine stops, even mid-frame. `irq_full` is high for exactly the following cycle, and the enable bit reads 0.
- R8: When a written byte carries `fifo_last` and the buffer is not full, the engine stops and `irq_end` is high for exactly the following cycle. The enable bit reads 0, and the byte count stays readable until the next arming.
- R9: When the byte that fills the buffer is also the last of its frame, only `irq_full` is raised.
- R10: While stopped, `mem_req` and `fifo_pop` stay low, and bytes remain in the FIFO.
- R11: Register writes made while the engine is armed are ignored.
- R12: An arming write that would give a length of zero is ignored in full: the enable bit stays 0 and no request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| fifo_empty | input | 1 | Receive FIFO holds no byte |
| fifo_data | input | 8 | Byte at the FIFO head |
| fifo_last | input | 1 | FIFO head byte ends its frame |
| fifo_pop | output | 1 | Remove the FIFO head this cycle |
| mem_req | output | 1 | Memory write request |
| mem_gnt | input | 1 | Bus grant; a write completes when high together with `mem_req` |
| mem_addr | output | 24 | Write address |
| mem_data | output | 8 | Write data |
| irq_full | output | 1 | One-cycle buffer-full interrupt |
| irq_end | output | 1 | One-cycle frame-end interrupt |

## Verification
The bench builds the engine with its default parameters: a 24-bit address and a 15-bit length. The wide address lets a run start at FFFFFE and show the pointer wrapping through zero. Because the length is wider than one byte, the restart write can move a length of 3 up to 0x103, so a frame that stopped at the old limit ends at its own last byte instead. The grant is driven always-on, alternating and held low, so that the engine sees stalled requests as well as back-to-back writes.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  typedef enum logic [1:0] {
    STOP_NONE = 2'd0,
    STOP_FULL = 2'd1,
    STOP_END  = 2'd2
  } stop_e;
endpackage

// File: rtl/rxdma_rst_sync.sv
module rxdma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/rxdma_regs.sv
module rxdma_regs #(
  parameter int ADDR_W = 24,
  parameter int SIZE_W = 15,
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              enable,
  input  logic [SIZE_W-1:0] count,
  output logic [ADDR_W-1:0] base,
  output logic [SIZE_W-1:0] size,
  output logic              arm
);
  localparam int NB    = ADDR_W / 8;
  localparam int SHI_W = SIZE_W - 8;
  localparam logic [REG_AW-1:0] OFS_SLO = REG_AW'(NB);
  localparam logic [REG_AW-1:0] OFS_SHI = REG_AW'(NB + 1);
  localparam logic [REG_AW-1:0] OFS_CLO = REG_AW'(NB + 2);
  localparam logic [REG_AW-1:0] OFS_CHI = REG_AW'(NB + 3);

  logic              wr_ok;
  logic [SIZE_W-1:0] size_wr;
  logic              zero_arm;
  logic              slo_en, shi_en;
  logic [7:0]        size_lo_q;
  logic [SHI_W-1:0]  size_hi_q;

  assign wr_ok    = reg_wr && !enable;
  assign size_wr  = {reg_wdata[SHI_W-1:0], size_lo_q};
  assign zero_arm = reg_wdata[7] && (size_wr == '0);
  assign slo_en   = wr_ok && (reg_addr == OFS_SLO);
  assign shi_en   = wr_ok && (reg_addr == OFS_SHI) && !zero_arm;
  assign arm      = shi_en && reg_wdata[7];
  assign size     = {size_hi_q, size_lo_q};

  for (genvar i = 0; i < NB; i++) begin : g_base
    logic [7:0] byte_q;
    logic       byte_en;
    assign byte_en = wr_ok && (reg_addr == REG_AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       byte_q <= 8'h00;
      else if (byte_en) byte_q <= reg_wdata;
    end
    assign base[i*8 +: 8] = byte_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      size_lo_q <= 8'h00;
    else if (slo_en) size_lo_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      size_hi_q <= '0;
    else if (shi_en) size_hi_q <= reg_wdata[SHI_W-1:0];
  end

  always_comb begin
    reg_rdata = 8'h00;
    for (int i = 0; i < NB; i++) begin
      if (reg_addr == REG_AW'(i)) reg_rdata = base[i*8 +: 8];
    end
    if (reg_addr == OFS_SLO) reg_rdata = size_lo_q;
    if (reg_addr == OFS_SHI) reg_rdata = {enable, 7'(size_hi_q)};
    if (reg_addr == OFS_CLO) reg_rdata = count[7:0];
    if (reg_addr == OFS_CHI) reg_rdata = 8'(count >> 8);
  end
endmodule

// File: rtl/rxdma_ctrl.sv
module rxdma_ctrl
  import rxdma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SIZE_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [ADDR_W-1:0] base,
  input  logic [SIZE_W-1:0] size,
  input  logic              fifo_empty,
  input  logic              fifo_last,
  input  logic              mem_gnt,
  output logic              enable,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              fifo_pop,
  output logic [SIZE_W-1:0] count,
  output logic              irq_full,
  output logic              irq_end
);
  logic              en_q, en_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [SIZE_W-1:0] cnt_q, cnt_d;
  logic              full_q, end_q;
  logic              accept;
  logic [SIZE_W-1:0] cnt_inc;
  stop_e             stop_kind;

  assign mem_req  = en_q && !fifo_empty;
  assign accept   = mem_req && mem_gnt;
  assign fifo_pop = accept;
  assign cnt_inc  = cnt_q + 1'b1;

  always_comb begin
    stop_kind = STOP_NONE;
    if (accept) begin
      if (cnt_inc == size) stop_kind = STOP_FULL;
      else if (fifo_last)  stop_kind = STOP_END;
    end
  end

  always_comb begin
    en_d  = en_q;
    ptr_d = ptr_q;
    cnt_d = cnt_q;
    if (arm) begin
      en_d  = 1'b1;
      ptr_d = base;
      cnt_d = '0;
    end else if (accept) begin
      ptr_d = ptr_q + 1'b1;
      cnt_d = cnt_inc;
      if (stop_kind != STOP_NONE) en_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ptr_q  <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
      end_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      ptr_q  <= ptr_d;
      cnt_q  <= cnt_d;
      full_q <= (stop_kind == STOP_FULL);
      end_q  <= (stop_kind == STOP_END);
    end
  end

  assign enable   = en_q;
  assign mem_addr = ptr_q;
  assign count    = cnt_q;
  assign irq_full = full_q;
  assign irq_end  = end_q;
endmodule

// File: rtl/rx_dma_engine.sv
module rx_dma_engine #(
  parameter int ADDR_W = 24,
  parameter int SIZE_W = 15,
  localparam int REG_AW = $clog2(ADDR_W / 8 + 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              fifo_empty,
  input  logic [7:0]        fifo_data,
  input  logic              fifo_last,
  output logic              fifo_pop,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_data,
  output logic              irq_full,
  output logic              irq_end
);
  logic              rst_n_sync;
  logic              enable, arm;
  logic [ADDR_W-1:0] base;
  logic [SIZE_W-1:0] size, count;

  rxdma_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_sync)
  );

  rxdma_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .REG_AW(REG_AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .enable   (enable),
    .count    (count),
    .base     (base),
    .size     (size),
    .arm      (arm)
  );

  rxdma_ctrl #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .arm       (arm),
    .base      (base),
    .size      (size),
    .fifo_empty(fifo_empty),
    .fifo_last (fifo_last),
    .mem_gnt   (mem_gnt),
    .enable    (enable),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .fifo_pop  (fifo_pop),
    .count     (count),
    .irq_full  (irq_full),
    .irq_end   (irq_end)
  );

  assign mem_data = fifo_data;
endmodule

// File: rtl/rxdma_checker.sv
module rxdma_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_data,
  input logic              fifo_pop,
  input logic              irq_full,
  input logic              irq_end
);
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt) |=> (mem_addr == $past(mem_addr) + 1'b1)); // R5

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_data))); // R6

  AST_FULL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_full |-> $past(mem_req && mem_gnt)); // R7

  AST_END_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_end |-> $past(mem_req && mem_gnt)); // R8

  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_full && irq_end)); // R9

  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_full || irq_end) |-> (!mem_req && !fifo_pop)); // R10
endmodule

bind rx_dma_engine rxdma_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mem_req (mem_req),
  .mem_gnt (mem_gnt),
  .mem_addr(mem_addr),
  .mem_data(mem_data),
  .fifo_pop(fifo_pop),
  .irq_full(irq_full),
  .irq_end (irq_end)
);

// File: tb/rx_dma_engine_tb.sv
module rx_dma_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        fifo_empty = 1'b1;
  logic [7:0]  fifo_data = 8'h00;
  logic        fifo_last = 1'b0;
  logic        fifo_pop;
  logic        mem_req;
  logic        mem_gnt = 1'b0;
  logic [23:0] mem_addr;
  logic [7:0]  mem_data;
  logic        irq_full, irq_end;

  rx_dma_engine u_dut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_err = 0, n_full = 0, n_end = 0, cyc = 0;
  int gnt_mode = 0;
  bit acc = 1'b0, tgl = 1'b0;
  logic [8:0]  fifo_q[$];
  logic [31:0] exp_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic refresh();
    fifo_empty = (fifo_q.size() == 0);
    fifo_data  = fifo_empty ? 8'h00 : fifo_q[0][7:0];
    fifo_last  = fifo_empty ? 1'b0 : fifo_q[0][8];
  endtask

  // driver side: stimulus into the FIFO model, expected writes into the scoreboard
  task automatic send(input int n, input logic [7:0] seed, input bit last);
    for (int i = 0; i < n; i++) fifo_q.push_back({last && (i == n - 1), 8'(seed + i)});
    refresh();
  endtask

  task automatic expect_writes(input logic [23:0] a, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) exp_q.push_back({24'(a + i), 8'(seed + i)});
  endtask

  // monitor: retires accepted bytes and compares each write with the scoreboard
  always @(negedge clk) begin
    cyc++;
    if (acc) begin
      void'(fifo_q.pop_front());
      refresh();
    end
    tgl = ~tgl;
    mem_gnt = (gnt_mode == 0) ? 1'b1 : (gnt_mode == 1) ? tgl : 1'b0;
    #1;
    acc = mem_req && mem_gnt;
    if (acc) begin
      if (exp_q.size() == 0) chk("R5 unexpected write", {mem_addr, mem_data}, 32'hxxxxxxxx);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk("R5 write addr/data", {mem_addr, mem_data}, e);
        chk("R5 pop with write", fifo_pop, 1);
      end
    end
    if (irq_full) n_full++;
    if (irq_end)  n_end++;
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #3; v = reg_rdata;
  endtask

  task automatic wait_stop(input bit want_full, input string tag);
    int f0, e0, t;
    f0 = n_full; e0 = n_end; t = 0;
    while (n_full == f0 && n_end == e0 && t < 400) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk({tag, " full pulses"}, n_full - f0, want_full ? 1 : 0);
    chk({tag, " end pulses"},  n_end - e0,  want_full ? 0 : 1);
    chk({tag, " all writes done"}, exp_q.size(), 0);
  endtask

  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 7; i++) begin rd(3'(i), v); chk("R1 reg reset", v, 0); end
    chk("R1 outputs idle", {mem_req, fifo_pop, irq_full, irq_end}, 0);

    // R2 / R3 / R8 frame ends before the buffer fills, alternating grant (R6)
    gnt_mode = 1;
    wr(0, 8'h56); wr(1, 8'h34); wr(2, 8'h12); wr(3, 8'h05);
    rd(1, v); chk("R2 base mid readback", v, 8'h34);
    rd(3, v); chk("R2 size low readback", v, 8'h05);
    wr(4, 8'h80);
    rd(4, v); chk("R3 enable set", v, 8'h80);
    expect_writes(24'h123456, 3, 8'h10);
    send(3, 8'h10, 1'b1);
    wait_stop(1'b0, "R8 frame end");
    rd(5, v); chk("R8 count kept", v, 3);
    rd(4, v); chk("R8 enable cleared", v, 8'h00);

    // R7 buffer full mid-frame, R10 back-pressure
    gnt_mode = 0;
    wr(0, 8'h00); wr(1, 8'h01); wr(2, 8'h00); wr(3, 8'h03); wr(4, 8'h80);
    expect_writes(24'h000100, 3, 8'h40);
    send(7, 8'h40, 1'b1);
    wait_stop(1'b1, "R7 buffer full");
    rd(4, v); chk("R7 enable cleared", v, 8'h00);
    repeat (8) @(negedge clk);
    chk("R10 fifo untouched", fifo_q.size(), 4);
    chk("R10 no request or pop", {mem_req, fifo_pop}, 0);

    // R4 restart with a larger length in the same write
    wr(1, 8'h20);
    expect_writes(24'h002000, 4, 8'h43);
    wr(4, 8'h81);
    wait_stop(1'b0, "R4 restart");
    rd(5, v); chk("R4 count of new run", v, 4);
    rd(4, v); chk("R4 size high loaded", v, 8'h01);

    // R11 writes ignored while armed, R9 fill on last byte
    gnt_mode = 2;
    wr(1, 8'h03); wr(3, 8'h02); wr(4, 8'h80);
    wr(0, 8'hAA); wr(3, 8'h09); wr(4, 8'h05);
    rd(0, v); chk("R11 base write ignored", v, 8'h00);
    rd(3, v); chk("R11 size write ignored", v, 8'h02);
    rd(4, v); chk("R11 enable still set", v, 8'h80);
    expect_writes(24'h000300, 2, 8'h70);
    send(2, 8'h70, 1'b1);
    gnt_mode = 0;
    wait_stop(1'b1, "R9 full wins");

    // R12 zero-length arming ignored
    wr(3, 8'h00); wr(4, 8'h80);
    rd(4, v); chk("R12 enable stays 0", v, 8'h00);
    send(1, 8'h90, 1'b0);
    repeat (5) @(negedge clk);
    chk("R12 no request", mem_req, 0);
    chk("R12 byte kept", fifo_q.size(), 1);

    // R5 pointer wraps through zero
    wr(0, 8'hFE); wr(1, 8'hFF); wr(2, 8'hFF); wr(3, 8'h05);
    expect_writes(24'hFFFFFE, 2, 8'h90);
    expect_writes(24'h000000, 1, 8'h92);
    send(2, 8'h91, 1'b1);
    wr(4, 8'h80);
    wait_stop(1'b0, "R5 wrap");
    rd(5, v); chk("R5 count after wrap", v, 3);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule